// File: doc/BRIEF.md
# Exception Vector Address Generator

This block produces the 64-bit virtual address that the processor branches to when it takes an exception. Exceptions come in two kinds: a TLB mismatch, or the common kind that covers everything else. The address depends on a bootstrap flag, on the privilege mode of the faulting address region, and on one extended-addressing enable per privilege mode. The block owns the bootstrap flag. It holds that flag in a two-state machine. In state `VEC_BOOT` the vectors sit in the boot ROM region. In state `VEC_RUN` they sit in the cached kernel segment.

The flag is forced to boot on reset and whenever a non-maskable interrupt is taken. Software moves it either way through a small status write port and can read it back. A reverse-endian control bit is also present in the write word, but only little-endian operation exists, so that bit is discarded. The vector address is combinational from the state and the current inputs, so it is valid in the same cycle the exception is signalled.

Transitions of the state machine:
- `T_RESET`: any state goes to `VEC_BOOT` on reset.
- `T_NMI`: any state goes to `VEC_BOOT` when an NMI is taken.
- `T_SW_CLEAR`: a write with the boot field 0 goes to `VEC_RUN`.
- `T_SW_SET`: a write with the boot field 1 goes to `VEC_BOOT`.
- `T_HOLD`: otherwise the state is kept.

Top module: `exc_vector_gen`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `stat_rdata[0]` (the bootstrap flag) reads 1.
- R2: When `nmi_take` is high at a clock edge, `stat_rdata[0]` reads 1 after that edge.
- R3: When `stat_we` is high and `nmi_take` is low at a clock edge, `stat_rdata[0]` takes the value of `stat_wdata[0]` after that edge. Without a write or an NMI, the flag holds its value.
- R4: When `nmi_take` and a write of `stat_wdata[0]=0` happen at the same edge, the flag ends up 1.
- R5: With the flag set, a TLB mismatch (`exc_tlb`=1) that does not select the extended vector yields 0xFFFFFFFF_BFC00200, and a common exception (`exc_tlb`=0) yields 0xFFFFFFFF_BFC00380.
- R6: With the flag clear, a TLB mismatch that does not select the extended vector yields 0xFFFFFFFF_80000000, and a common exception yields 0xFFFFFFFF_80000180.
- R7: `priv_mode` is encoded as 0 = kernel, 1 = supervisor and 2 = user. The extended enables are `ext_en[0]` for kernel, `ext_en[1]` for supervisor and `ext_en[2]` for user. A TLB mismatch whose mode has its enable set yields the normal TLB vector plus 0x80, with the flag either set or clear.
- R8: The enable bits of the modes other than `priv_mode` have no effect on the vector. No enable bit affects a common-exception vector.
- R9: `priv_mode`=3 (reserved) always yields the normal TLB-mismatch vector on a TLB mismatch.
- R10: `stat_wdata[1]` (reverse endian) has no effect. `stat_rdata[1]` always reads 0, and neither the flag nor the vector changes because of it.
- R11: `vec_addr` reflects a change of `exc_tlb`, `priv_mode` or `ext_en` in the same cycle, with no clock edge between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| nmi_take | input | 1 | Pulse: an NMI exception is being taken |
| stat_we | input | 1 | Status write strobe |
| stat_wdata | input | 2 | Write data: [0] bootstrap flag, [1] reverse endian |
| stat_rdata | output | 2 | Readback: [0] bootstrap flag, [1] reverse endian (always 0) |
| exc_tlb | input | 1 | 1 = TLB mismatch, 0 = common exception |
| priv_mode | input | 2 | Mode of the faulting region: 0 kernel, 1 supervisor, 2 user, 3 reserved |
| ext_en | input | 3 | Extended-addressing enables: [0] kernel, [1] supervisor, [2] user |
| vec_addr | output | 64 | Exception vector virtual address |

## Verification
The assertions watch every cycle for the flag's update rules: the forced set on NMI, the priority of NMI over a write, the copy on a write, and hold otherwise. They also check that every vector lies in the sign-extended top region, that common vectors end in 0x80, and that an enabled kernel TLB mismatch selects the extended slot. Only the bench's reference model can show the full 64-bit values for each mode and enable combination. It also covers the independence from the other modes' enables, the reserved mode, the ignored endian bit, and the same-cycle response to changed inputs.

// File: rtl/evg_pkg.sv
package evg_pkg;

    typedef enum logic [0:0] {
        VEC_BOOT = 1'b0,
        VEC_RUN  = 1'b1
    } boot_st_e;

    typedef enum logic [1:0] {
        PM_KERNEL = 2'd0,
        PM_SUPER  = 2'd1,
        PM_USER   = 2'd2,
        PM_RSVD   = 2'd3
    } priv_e;

    localparam int NUM_MODES  = 3;
    localparam int WB_BOOT    = 0;
    localparam int WB_REVEND  = 1;
    localparam int STAT_W     = 2;

endpackage

// File: rtl/evg_boot_fsm.sv
module evg_boot_fsm
    import evg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic nmi_take,
    input  logic wr_en,
    input  logic wr_boot,
    output logic boot_o
);

    boot_st_e state_q;
    boot_st_e state_d;

    // State register: reset forces boot (T_RESET)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= VEC_BOOT;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: NMI outranks a software write
    always_comb begin
        state_d = state_q;
        if (nmi_take) begin
            state_d = VEC_BOOT;                         // T_NMI
        end else if (wr_en) begin
            state_d = wr_boot ? VEC_BOOT : VEC_RUN;     // T_SW_SET / T_SW_CLEAR
        end
    end

    // Outputs
    always_comb begin
        unique case (state_q)
            VEC_BOOT: boot_o = 1'b1;
            VEC_RUN:  boot_o = 1'b0;
            default:  boot_o = 1'b1;
        endcase
    end

endmodule

// File: rtl/evg_ext_select.sv
module evg_ext_select
    import evg_pkg::*;
(
    input  logic [1:0]           priv_mode,
    input  logic [NUM_MODES-1:0] ext_en,
    output logic                 use_ext
);

    logic [NUM_MODES-1:0] hit;

    // One decoder leg per privilege mode
    for (genvar m = 0; m < NUM_MODES; m++) begin : g_mode
        assign hit[m] = ext_en[m] && (priv_mode == 2'(m));
    end

    assign use_ext = |hit;

endmodule

// File: rtl/evg_addr_mux.sv
module evg_addr_mux #(
    parameter int                ADDR_W    = 64,
    parameter logic [31:0]       BOOT_BASE = 32'hBFC0_0000,
    parameter logic [31:0]       RUN_BASE  = 32'h8000_0000,
    parameter logic [11:0]       BOOT_TLB  = 12'h200,
    parameter logic [11:0]       RUN_TLB   = 12'h000,
    parameter logic [11:0]       CMN_OFF   = 12'h180,
    parameter logic [11:0]       EXT_STEP  = 12'h080
) (
    input  logic              boot,
    input  logic              exc_tlb,
    input  logic              use_ext,
    output logic [ADDR_W-1:0] vec_addr
);

    localparam int HI_W = ADDR_W - 32;

    // Boot region places every vector 0x200 above its running position
    localparam logic [11:0] BOOT_CMN = CMN_OFF + (BOOT_TLB - RUN_TLB);

    logic [31:0] base;
    logic [11:0] off;

    always_comb begin
        base = boot ? BOOT_BASE : RUN_BASE;
        if (exc_tlb) begin
            off = boot ? BOOT_TLB : RUN_TLB;
            if (use_ext) begin
                off = off + EXT_STEP;
            end
        end else begin
            off = boot ? BOOT_CMN : CMN_OFF;
        end
    end

    // Sign-extended 32-bit kernel address
    assign vec_addr = {{HI_W{base[31]}}, base + {20'd0, off}};

endmodule

// File: rtl/exc_vector_gen.sv
module exc_vector_gen
    import evg_pkg::*;
#(
    parameter int ADDR_W = 64
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 nmi_take,
    input  logic                 stat_we,
    input  logic [STAT_W-1:0]    stat_wdata,
    output logic [STAT_W-1:0]    stat_rdata,
    input  logic                 exc_tlb,
    input  logic [1:0]           priv_mode,
    input  logic [NUM_MODES-1:0] ext_en,
    output logic [ADDR_W-1:0]    vec_addr
);

    logic boot;
    logic use_ext;

    evg_boot_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .nmi_take (nmi_take),
        .wr_en    (stat_we),
        .wr_boot  (stat_wdata[WB_BOOT]),
        .boot_o   (boot)
    );

    evg_ext_select u_sel (
        .priv_mode (priv_mode),
        .ext_en    (ext_en),
        .use_ext   (use_ext)
    );

    evg_addr_mux #(.ADDR_W(ADDR_W)) u_mux (
        .boot     (boot),
        .exc_tlb  (exc_tlb),
        .use_ext  (use_ext),
        .vec_addr (vec_addr)
    );

    // Little-endian only: the written endian request is masked off
    assign stat_rdata[WB_BOOT]   = boot;
    assign stat_rdata[WB_REVEND] = stat_wdata[WB_REVEND] & 1'b0;

endmodule

// File: rtl/exc_vector_gen_chk.sv
module exc_vector_gen_chk #(
    parameter int ADDR_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              nmi_take,
    input logic              stat_we,
    input logic [1:0]        stat_wdata,
    input logic [1:0]        stat_rdata,
    input logic              exc_tlb,
    input logic [1:0]        priv_mode,
    input logic [2:0]        ext_en,
    input logic [ADDR_W-1:0] vec_addr
);

    a_r1_boot_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> stat_rdata[0]);

    a_r2_nmi_forces_boot: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_take |=> stat_rdata[0]);

    a_r3_write_copies: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_we && !nmi_take) |=> (stat_rdata[0] == $past(stat_wdata[0])));

    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!stat_we && !nmi_take) |=> $stable(stat_rdata[0]));

    a_r4_nmi_beats_write: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi_take && stat_we && !stat_wdata[0]) |=> stat_rdata[0]);

    a_r5_top_region: assert property (@(posedge clk) disable iff (!rst_n)
        vec_addr[ADDR_W-1:31] == '1);

    a_r8_common_slot: assert property (@(posedge clk) disable iff (!rst_n)
        !exc_tlb |-> (vec_addr[7:0] == 8'h80));

    a_r7_kernel_ext: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_tlb && priv_mode == 2'd0 && ext_en[0]) |-> (vec_addr[7:0] == 8'h80));

endmodule

bind exc_vector_gen exc_vector_gen_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .nmi_take   (nmi_take),
    .stat_we    (stat_we),
    .stat_wdata (stat_wdata),
    .stat_rdata (stat_rdata),
    .exc_tlb    (exc_tlb),
    .priv_mode  (priv_mode),
    .ext_en     (ext_en),
    .vec_addr   (vec_addr)
);

// File: tb/exc_vector_gen_bench.sv
`timescale 1ns/1ps
module exc_vector_gen_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        nmi_take = 1'b0;
    logic        stat_we = 1'b0;
    logic [1:0]  stat_wdata = 2'b00;
    logic [1:0]  stat_rdata;
    logic        exc_tlb = 1'b0;
    logic [1:0]  priv_mode = 2'd0;
    logic [2:0]  ext_en = 3'b000;
    logic [63:0] vec_addr;

    int checks = 0;
    int errors = 0;
    bit model_boot = 1'b1;

    always #2.5 clk = ~clk;

    exc_vector_gen u_exc_vector_gen (
        .clk        (clk),
        .rst_n      (rst_n),
        .nmi_take   (nmi_take),
        .stat_we    (stat_we),
        .stat_wdata (stat_wdata),
        .stat_rdata (stat_rdata),
        .exc_tlb    (exc_tlb),
        .priv_mode  (priv_mode),
        .ext_en     (ext_en),
        .vec_addr   (vec_addr)
    );

    function automatic logic [63:0] expect_vec(bit bt, bit tlb, bit [1:0] pm, bit [2:0] ee);
        longint unsigned a;
        bit ext;
        a = bt ? 64'hFFFF_FFFF_BFC0_0000 : 64'hFFFF_FFFF_8000_0000;
        if (tlb) begin
            ext = (pm == 2'd3) ? 1'b0 : ee[pm];
            a = a + (bt ? 64'h200 : 64'h0) + (ext ? 64'h80 : 64'h0);
        end else begin
            a = a + (bt ? 64'h380 : 64'h180);
        end
        return a;
    endfunction

    task automatic check_now(string tag);
        logic [63:0] ev;
        ev = expect_vec(model_boot, exc_tlb, priv_mode, ext_en);
        checks++;
        if (vec_addr !== ev) begin
            errors++;
            $display("FAIL %s vec_addr actual=%h expected=%h", tag, vec_addr, ev);
        end
        checks++;
        if (stat_rdata !== {1'b0, model_boot}) begin
            errors++;
            $display("FAIL %s stat_rdata actual=%b expected=%b", tag, stat_rdata, {1'b0, model_boot});
        end
    endtask

    // Apply at negedge, check combinationally, then clock and advance model
    task automatic step(string tag, bit rs, bit nmi, bit we, bit [1:0] wd,
                        bit tlb, bit [1:0] pm, bit [2:0] ee);
        rst_n = rs; nmi_take = nmi; stat_we = we; stat_wdata = wd;
        exc_tlb = tlb; priv_mode = pm; ext_en = ee;
        if (!rs) model_boot = 1'b1;
        #1;
        check_now(tag);
        @(posedge clk);
        if (!rs || nmi) model_boot = 1'b1;
        else if (we) model_boot = wd[0];
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 5);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        bit [15:0] lfsr;
        @(negedge clk);
        step("R1", 0, 0, 0, 2'b00, 1, 2'd0, 3'b000);
        step("R1", 0, 0, 1, 2'b00, 0, 2'd0, 3'b000);
        step("R1", 1, 0, 0, 2'b00, 1, 2'd1, 3'b000);
        step("R5", 1, 0, 0, 2'b00, 0, 2'd2, 3'b111);
        step("R7", 1, 0, 0, 2'b00, 1, 2'd2, 3'b100);
        step("R3", 1, 0, 1, 2'b00, 1, 2'd0, 3'b000);
        step("R6", 1, 0, 0, 2'b00, 1, 2'd0, 3'b000);
        step("R6", 1, 0, 0, 2'b00, 0, 2'd0, 3'b111);
        step("R7", 1, 0, 0, 2'b00, 1, 2'd0, 3'b001);
        step("R7", 1, 0, 0, 2'b00, 1, 2'd1, 3'b010);
        step("R7", 1, 0, 0, 2'b00, 1, 2'd2, 3'b100);
        step("R8", 1, 0, 0, 2'b00, 1, 2'd1, 3'b101);
        step("R8", 1, 0, 0, 2'b00, 1, 2'd0, 3'b110);
        step("R9", 1, 0, 0, 2'b00, 1, 2'd3, 3'b111);
        step("R10", 1, 0, 1, 2'b10, 1, 2'd0, 3'b000);
        step("R10", 1, 0, 0, 2'b10, 1, 2'd0, 3'b000);
        step("R4", 1, 1, 1, 2'b00, 0, 2'd0, 3'b000);
        step("R4", 1, 0, 1, 2'b00, 0, 2'd0, 3'b000);
        step("R2", 1, 1, 0, 2'b00, 1, 2'd1, 3'b010);
        step("R3", 1, 0, 0, 2'b00, 1, 2'd1, 3'b010);
        step("R10", 1, 0, 1, 2'b11, 1, 2'd3, 3'b000);
        // R11: inputs change every cycle, output must follow at once
        lfsr = 16'hACE1;
        for (int i = 0; i < 300; i++) begin
            bit rs;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            rs = (lfsr[15:11] != 5'd0);
            step("R11", rs, lfsr[0] & lfsr[5] & lfsr[9], lfsr[1] & lfsr[6],
                 lfsr[3:2], lfsr[4], lfsr[8:7], lfsr[12:10]);
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule